// File: doc/BRIEF.md
# Shadowed PWM Configuration Register Bank

This block holds the configuration of a PWM timer with up to sixteen channels and hands the values in force to a waveform generator. Software reaches it over a simple synchronous request bus that uses 8-bit data and byte addresses. Each channel has a rising-edge position, a falling-edge position and an enable bit. All channels share a prescale value and a period value.

A build-time mask picks which channels get a shadow copy of their settings. A write to an unshadowed channel takes effect on the next clock. A write to a shadowed channel, while synchronous update is switched on, lands only in the shadow copy. It moves into the active set at the next period boundary, so the waveform never sees a half-updated setting. When any channel is shadowed, the prescale and period registers are shadowed as well. A read always returns the setting currently in force.

The bank contains a small timebase built from the active prescale and period. It marks each period boundary and drives a one-cycle period-start strobe to the waveform generator.

Top module: `pwm_shadow_regbank`

## Requirements
- R1: After reset, every active and shadow register reads as zero, synchronous update is off, and all exported values are zero.
- R2: A request with `req_valid` high is accepted in the same cycle, so there is no back-pressure. A read (`req_we` low) produces `rsp_valid` high for one cycle on the next clock, with the data in `rsp_data`. A write produces no response.
- R3: Address map:
  - 0x00 holds the prescale value and 0x04 holds the period value.
  - 0x08 holds the enables of channels 0..7, with bit k for channel k.
  - 0x0C holds the enables of channels 8..15, with bit k for channel 8+k.
  - The rising-edge value of channel i is at 0x10+8*i and its falling-edge value is at 0x14+8*i.
  - 0xE4 is the synchronous-update control, in bit 0.
- R4: A write to a channel that is not in `SHADOW_MASK` is visible on readback and on the exported outputs one cycle later, whether synchronous update is on or off.
- R5: While synchronous update is on, a write to a shadowed channel leaves the active value unchanged until the current period ends. The new value appears in the cycle in which `period_start` is high, and readback shows the old value until then.
- R6: While synchronous update is off, writes to shadowed channels take effect one cycle later, like writes to unshadowed ones.
- R7: If `SHADOW_MASK` is nonzero, prescale and period follow the shadowed rules of R5 and R6. If it is zero, they follow R4.
- R8: `period_start` is high in the first cycle of each period. A period lasts (prescale+1)*(period+1) clock cycles, using the active values.
- R9: An enable-register write applies its bits channel by channel. Bits of unshadowed channels take effect at once, and bits of shadowed channels follow R5 and R6.
- R10: Addresses not listed in R3 are unmapped. Writes to them change nothing, and reads from them return zero. This includes misaligned addresses inside the edge range.
- R11: A write to 0xE4 sets synchronous update to bit 0 of the data. A read of 0xE4 returns that bit in bit 0, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; always accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data (active setting) |
| period_start | output | 1 | High in the first cycle of each period |
| act_prescale | output | 8 | Active prescale value |
| act_period | output | 8 | Active period value |
| act_enable | output | NUM_CH | Active channel enables |
| act_rise | output | 8*NUM_CH | Active rising-edge values, channel i in bits 8i+7:8i |
| act_fall | output | 8*NUM_CH | Active falling-edge values, channel i in bits 8i+7:8i |

## Verification
The bench builds the bank with all sixteen channels and `SHADOW_MASK` = 0x00F0. Channels 4..7 are therefore shadowed and the rest are not, which also shadows prescale and period. This mix lets one enable byte contain both immediate and deferred bits, and it lets shadowed and unshadowed channels be compared under the same synchronous-update setting. With prescale 3 and period 9, a period is 40 cycles long. That leaves enough room to write and read back inside one period before the commit, and it makes a committed period change measurable as a new strobe interval.

// File: rtl/pwmrb_pkg.sv
`timescale 1ns/1ps
package pwmrb_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int MAX_CH = 16;

  localparam logic [AW-1:0] ADR_PRE     = 8'h00;
  localparam logic [AW-1:0] ADR_PER     = 8'h04;
  localparam logic [AW-1:0] ADR_EN_LO   = 8'h08;
  localparam logic [AW-1:0] ADR_EN_HI   = 8'h0C;
  localparam logic [AW-1:0] ADR_SYNC    = 8'hE4;
  localparam logic [AW-1:0] ADR_EDGE_LO = 8'h10;
  localparam logic [AW-1:0] ADR_EDGE_HI = 8'h8F;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PRE, SEL_PER, SEL_EN, SEL_RISE, SEL_FALL, SEL_SYNC
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic [3:0] idx;
  } dec_t;

  function automatic dec_t decode(input logic [AW-1:0] a, input int nch);
    dec_t d;
    logic [AW-1:0] off;
    d.sel = SEL_NONE;
    d.idx = '0;
    off   = a - ADR_EDGE_LO;
    if (a == ADR_PRE) d.sel = SEL_PRE;
    else if (a == ADR_PER) d.sel = SEL_PER;
    else if (a == ADR_EN_LO) d.sel = SEL_EN;
    else if (a == ADR_EN_HI && nch > 8) begin
      d.sel = SEL_EN;
      d.idx = 4'd1;
    end
    else if (a == ADR_SYNC) d.sel = SEL_SYNC;
    else if (a >= ADR_EDGE_LO && a <= ADR_EDGE_HI && a[1:0] == 2'b00
             && int'(off[6:3]) < nch) begin
      d.sel = off[2] ? SEL_FALL : SEL_RISE;
      d.idx = off[6:3];
    end
    return d;
  endfunction
endpackage

// File: rtl/pwmrb_cell.sv
`timescale 1ns/1ps
module pwmrb_cell #(
  parameter int W        = 8,
  parameter bit SHADOWED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wd,
  input  logic         defer,
  input  logic         commit,
  output logic [W-1:0] act
);
  generate
    if (SHADOWED) begin : g_shd
      logic [W-1:0] shd_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          act   <= '0;
          shd_q <= '0;
        end else begin
          if (commit) act <= shd_q;
          if (wr) begin
            shd_q <= wd;
            if (!defer) act <= wd;
          end
        end
      end
    end else begin : g_dir
      logic unused_ctl;
      assign unused_ctl = defer ^ commit;
      always_ff @(posedge clk) begin
        if (!rst_n) act <= '0;
        else if (wr) act <= wd;
      end
    end
  endgenerate
endmodule

// File: rtl/pwmrb_timebase.sv
`timescale 1ns/1ps
module pwmrb_timebase #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pre_lim,
  input  logic [W-1:0] per_lim,
  output logic         wrap,
  output logic         period_start
);
  logic [W-1:0] pre_cnt, step_cnt;
  logic pre_end, step_end;

  assign pre_end  = pre_cnt >= pre_lim;
  assign step_end = step_cnt >= per_lim;
  assign wrap     = pre_end && step_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt      <= '0;
      step_cnt     <= '0;
      period_start <= 1'b0;
    end else begin
      period_start <= wrap;
      if (pre_end) begin
        pre_cnt  <= '0;
        step_cnt <= step_end ? '0 : step_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwmrb_readmux.sv
`timescale 1ns/1ps
module pwmrb_readmux
  import pwmrb_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd,
  input  dec_t                         dec,
  input  logic [DW-1:0]                pre,
  input  logic [DW-1:0]                per,
  input  logic [MAX_CH-1:0]            en,
  input  logic [NUM_CH-1:0][DW-1:0]    rise,
  input  logic [NUM_CH-1:0][DW-1:0]    fall,
  input  logic                         sync_en,
  output logic                         rsp_valid,
  output logic [DW-1:0]                rsp_data
);
  logic [DW-1:0] val;

  always_comb begin
    val = '0;
    unique case (dec.sel)
      SEL_PRE:  val = pre;
      SEL_PER:  val = per;
      SEL_EN:   val = dec.idx[0] ? en[15:8] : en[7:0];
      SEL_RISE: val = rise[dec.idx];
      SEL_FALL: val = fall[dec.idx];
      SEL_SYNC: val = {{(DW-1){1'b0}}, sync_en};
      default:  val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= val;
    end
  end
endmodule

// File: rtl/pwm_shadow_regbank.sv
`timescale 1ns/1ps
module pwm_shadow_regbank
  import pwmrb_pkg::*;
#(
  parameter int              NUM_CH      = 16,
  parameter logic [15:0]     SHADOW_MASK = 16'hFFFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_we,
  input  logic [7:0]             req_addr,
  input  logic [7:0]             req_wdata,
  output logic                   rsp_valid,
  output logic [7:0]             rsp_data,
  output logic                   period_start,
  output logic [7:0]             act_prescale,
  output logic [7:0]             act_period,
  output logic [NUM_CH-1:0]      act_enable,
  output logic [NUM_CH*8-1:0]    act_rise,
  output logic [NUM_CH*8-1:0]    act_fall
);
  localparam bit ANY_SHADOW = |SHADOW_MASK[NUM_CH-1:0];

  dec_t dec;
  logic wr, rd, wrap, commit, sync_en;
  logic [NUM_CH-1:0][DW-1:0] rise_a, fall_a;
  logic [MAX_CH-1:0] en_pad;

  assign dec    = decode(req_addr, NUM_CH);
  assign wr     = req_valid && req_we;
  assign rd     = req_valid && !req_we;
  assign commit = wrap && sync_en;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_en <= 1'b0;
    else if (wr && dec.sel == SEL_SYNC) sync_en <= req_wdata[0];
  end

  pwmrb_timebase #(.W(DW)) u_tb (
    .clk(clk), .rst_n(rst_n), .pre_lim(act_prescale), .per_lim(act_period),
    .wrap(wrap), .period_start(period_start)
  );

  pwmrb_cell #(.W(DW), .SHADOWED(ANY_SHADOW)) u_pre (
    .clk(clk), .rst_n(rst_n), .wr(wr && dec.sel == SEL_PRE), .wd(req_wdata),
    .defer(sync_en), .commit(commit), .act(act_prescale)
  );

  pwmrb_cell #(.W(DW), .SHADOWED(ANY_SHADOW)) u_per (
    .clk(clk), .rst_n(rst_n), .wr(wr && dec.sel == SEL_PER), .wd(req_wdata),
    .defer(sync_en), .commit(commit), .act(act_period)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [3:0] CH  = 4'(i);
      localparam logic [3:0] GRP = 4'(i / 8);
      pwmrb_cell #(.W(DW), .SHADOWED(SHADOW_MASK[i])) u_rise (
        .clk(clk), .rst_n(rst_n), .wr(wr && dec.sel == SEL_RISE && dec.idx == CH),
        .wd(req_wdata), .defer(sync_en), .commit(commit), .act(rise_a[i])
      );
      pwmrb_cell #(.W(DW), .SHADOWED(SHADOW_MASK[i])) u_fall (
        .clk(clk), .rst_n(rst_n), .wr(wr && dec.sel == SEL_FALL && dec.idx == CH),
        .wd(req_wdata), .defer(sync_en), .commit(commit), .act(fall_a[i])
      );
      pwmrb_cell #(.W(1), .SHADOWED(SHADOW_MASK[i])) u_en (
        .clk(clk), .rst_n(rst_n), .wr(wr && dec.sel == SEL_EN && dec.idx == GRP),
        .wd(req_wdata[i % 8]), .defer(sync_en), .commit(commit), .act(act_enable[i])
      );
      assign act_rise[i*8 +: 8] = rise_a[i];
      assign act_fall[i*8 +: 8] = fall_a[i];
    end
  endgenerate

  always_comb begin
    en_pad = '0;
    en_pad[NUM_CH-1:0] = act_enable;
  end

  pwmrb_readmux #(.NUM_CH(NUM_CH)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(rd), .dec(dec),
    .pre(act_prescale), .per(act_period), .en(en_pad),
    .rise(rise_a), .fall(fall_a), .sync_en(sync_en),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/pwm_shadow_regbank_chk.sv
`timescale 1ns/1ps
module pwm_shadow_regbank_chk
  import pwmrb_pkg::*;
#(
  parameter int          NUM_CH      = 16,
  parameter logic [15:0] SHADOW_MASK = 16'hFFFF
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_we,
  input logic [7:0]          req_addr,
  input logic [7:0]          req_wdata,
  input logic                rsp_valid,
  input logic [7:0]          rsp_data,
  input logic                period_start,
  input logic [7:0]          act_prescale,
  input logic [7:0]          act_period,
  input logic [NUM_CH*8-1:0] act_rise,
  input logic [NUM_CH*8-1:0] act_fall
);
  localparam bit ANY_SHADOW = |SHADOW_MASK[NUM_CH-1:0];

  logic chk_sync;
  logic wr;
  assign wr = req_valid && req_we;

  always_ff @(posedge clk) begin
    if (!rst_n) chk_sync <= 1'b0;
    else if (wr && req_addr == 8'hE4) chk_sync <= req_wdata[0];
  end

  // R2: a response only follows an accepted read
  a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_we));

  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(decode(req_addr, NUM_CH).sel == SEL_NONE)) |-> rsp_data == 8'h00);

  generate
    if (ANY_SHADOW) begin : g_tb_shd
      // R7: shadowed timebase changes only at a boundary or by an undeferred write
      a_r7_prescale_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_prescale) |-> (period_start || $past(wr && req_addr == 8'h00 && !chk_sync)));
      a_r7_period_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_period) |-> (period_start || $past(wr && req_addr == 8'h04 && !chk_sync)));
    end
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [7:0] A_R = 8'(8'h10 + 8 * i);
      localparam logic [7:0] A_F = 8'(8'h14 + 8 * i);
      if (SHADOW_MASK[i]) begin : g_s
        // R5/R6: shadowed edge changes only at a boundary or by an undeferred write
        a_r5_rise_boundary: assert property (@(posedge clk) disable iff (!rst_n)
          !$stable(act_rise[i*8 +: 8]) |-> (period_start || $past(wr && req_addr == A_R && !chk_sync)));
        a_r5_fall_boundary: assert property (@(posedge clk) disable iff (!rst_n)
          !$stable(act_fall[i*8 +: 8]) |-> (period_start || $past(wr && req_addr == A_F && !chk_sync)));
      end else begin : g_u
        // R4: unshadowed edge follows a write on the next cycle
        a_r4_rise_direct: assert property (@(posedge clk) disable iff (!rst_n)
          (wr && req_addr == A_R) |=> act_rise[i*8 +: 8] == $past(req_wdata));
        a_r4_fall_direct: assert property (@(posedge clk) disable iff (!rst_n)
          (wr && req_addr == A_F) |=> act_fall[i*8 +: 8] == $past(req_wdata));
      end
    end
  endgenerate
endmodule

bind pwm_shadow_regbank pwm_shadow_regbank_chk #(.NUM_CH(NUM_CH), .SHADOW_MASK(SHADOW_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .period_start(period_start), .act_prescale(act_prescale), .act_period(act_period),
  .act_rise(act_rise), .act_fall(act_fall)
);

// File: tb/pwm_shadow_regbank_tb.sv
`timescale 1ns/1ps
module pwm_shadow_regbank_tb;
  localparam int          NUM_CH = 16;
  localparam logic [15:0] MASK   = 16'h00F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid, period_start;
  logic [7:0] rsp_data, act_prescale, act_period;
  logic [NUM_CH-1:0] act_enable;
  logic [NUM_CH*8-1:0] act_rise, act_fall;

  always #2.5 clk = ~clk;

  pwm_shadow_regbank #(.NUM_CH(NUM_CH), .SHADOW_MASK(MASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .period_start(period_start), .act_prescale(act_prescale),
    .act_period(act_period), .act_enable(act_enable), .act_rise(act_rise),
    .act_fall(act_fall)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each read response against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R2 response without read", 32'd1, 32'd0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'd0, rsp_data}, {24'd0, e});
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_ps();
    do @(negedge clk); while (period_start !== 1'b1);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (period_start !== 1'b1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int len;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 act_prescale", {24'd0, act_prescale}, 32'd0);
    check("R1 act_enable", {16'd0, act_enable}, 32'd0);
    rd(8'h00, 8'h00, "R1 prescale reset");
    rd(8'h04, 8'h00, "R1 period reset");
    rd(8'h0C, 8'h00, "R1 enable hi reset");
    rd(8'h30, 8'h00, "R1 ch4 rise reset");
    rd(8'hE4, 8'h00, "R1 sync reset");

    // R7 with sync off: immediate; R8 period length
    wr(8'h00, 8'd3);
    wr(8'h04, 8'd9);
    rd(8'h00, 8'd3, "R7 prescale immediate when sync off");
    wait_ps();
    measure(len);
    check("R8 period 4x10", len, 32'd40);

    // R11 sync control
    wr(8'hE4, 8'hFF);
    rd(8'hE4, 8'h01, "R11 sync readback");

    // R5 shadowed channel 4 rise (R3 address 0x30)
    wait_ps();
    wr(8'h30, 8'h5A);
    rd(8'h30, 8'h00, "R5 ch4 rise held before boundary");
    check("R5 ch4 rise port held", {24'd0, act_rise[39:32]}, 32'd0);
    wait_ps();
    check("R5 ch4 rise port at period_start", {24'd0, act_rise[39:32]}, 32'h5A);
    rd(8'h30, 8'h5A, "R5 ch4 rise after boundary");

    // R4 unshadowed channels with sync on, R3 edge addresses
    wr(8'h14, 8'h33);
    rd(8'h14, 8'h33, "R4 ch0 fall immediate");
    wr(8'h88, 8'h77);
    rd(8'h88, 8'h77, "R3 ch15 rise at 0x88");
    wr(8'h8C, 8'h78);
    rd(8'h8C, 8'h78, "R3 ch15 fall at 0x8C");
    check("R4 ch15 fall port", {24'd0, act_fall[127:120]}, 32'h78);

    // R9 mixed enable byte
    wait_ps();
    wr(8'h08, 8'hFF);
    rd(8'h08, 8'h0F, "R9 enable lo partial before boundary");
    wr(8'h0C, 8'hA5);
    rd(8'h0C, 8'hA5, "R9 enable hi immediate");
    wait_ps();
    rd(8'h08, 8'hFF, "R9 enable lo after boundary");
    check("R9 act_enable port", {16'd0, act_enable}, 32'h0000A5FF);

    // R7 shadowed period change takes effect at boundary
    wait_ps();
    wr(8'h04, 8'd4);
    rd(8'h04, 8'd9, "R7 period held before boundary");
    wait_ps();
    measure(len);
    check("R7 new period 4x5", len, 32'd20);
    rd(8'h04, 8'd4, "R7 period after boundary");

    // R6 sync off: shadowed channel 5 fall (0x3C) immediate
    wr(8'hE4, 8'h00);
    rd(8'hE4, 8'h00, "R11 sync cleared");
    wr(8'h3C, 8'h66);
    rd(8'h3C, 8'h66, "R6 ch5 fall immediate with sync off");

    // R10 unmapped
    wr(8'h11, 8'hEE);
    rd(8'h11, 8'h00, "R10 misaligned read zero");
    rd(8'h10, 8'h00, "R10 ch0 rise untouched by misaligned write");
    wr(8'h90, 8'h12);
    rd(8'h90, 8'h00, "R10 past edge range read zero");
    rd(8'hE8, 8'h00, "R10 unmapped 0xE8");
    check("R10 ch0 rise port untouched", {24'd0, act_rise[7:0]}, 32'd0);

    repeat (3) @(negedge clk);
    check("R2 all reads answered", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule